// File: doc/BRIEF.md
# Write-Hold Extending Bidirectional Data Buffer

This block sits between a processor data bus and a slow peripheral. That peripheral needs its write data to stay valid long after its write strobe ends. While a selected write is in progress, the block tracks the processor data. When the active-low write strobe rises, it commits the tracked value into an output latch. It then keeps that value on the peripheral data lines after the strobe has gone. The processor's bus cycle is never stretched and no wait states are inserted.

The buffer works in both directions. During a selected, active-low read, the peripheral's data is passed to the processor and the latched peripheral drive is released. A hold timer runs for a set number of clock cycles after each commit. If a new selected write starts while the timer is still running, a sticky violation flag is raised. The new write is still accepted, so the processor timing stays untouched. Select, write and read are asynchronous to the system clock and pass through two-stage synchronisers, as does the processor data bus.

Top module: `hold_extend_buffer`

## Requirements
- R1: After reset, per_oe, host_oe, hold_busy and hold_viol are 0 and per_dout is all zeros; per_dout stays zero until the first selected write completes.
- R2: For a write with sel_n low, per_dout takes the host_din value that was stable while wr_n was low. It shows this value by the third rising clock edge after wr_n goes high, even if host_din changes when wr_n rises.
- R3: After the first selected write completes, per_oe is 1 and remains 1 with wr_n high, for as long as no selected read is in progress.
- R4: A write strobe pulse while sel_n is high leaves per_dout unchanged.
- R5: While sel_n and rd_n are both low (and wr_n high), host_oe is 1, host_dout equals per_din and per_oe is 0. Once the read ends, per_oe returns to 1 and host_oe to 0.
- R6: A read with sel_n high leaves host_oe at 0 and host_dout at zero, and per_oe keeps its value.
- R7: hold_busy is 1 for exactly HOLD_CYC clock cycles, starting on the same edge at which per_dout takes a new committed value.
- R8: A selected write that starts while hold_busy is 1 sets hold_viol. hold_viol then stays 1 until reset, and the new write's data is still committed to per_dout.
- R9: Selected writes that each start after hold_busy has returned to 0 leave hold_viol at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select from the processor |
| wr_n | input | 1 | Active-low write strobe from the processor |
| rd_n | input | 1 | Active-low read strobe from the processor |
| host_din | input | W | Processor data bus toward the buffer |
| host_dout | output | W | Data from the buffer toward the processor |
| host_oe | output | 1 | Enables the buffer's drive onto the processor bus |
| per_din | input | W | Peripheral data bus toward the buffer |
| per_dout | output | W | Latched write data toward the peripheral |
| per_oe | output | 1 | Enables the buffer's drive onto the peripheral bus |
| hold_busy | output | 1 | Hold interval of the last committed write is running |
| hold_viol | output | 1 | Sticky: a write began inside a hold interval |

## Verification
The rising edge of wr_n passes through two synchroniser stages and one output register. The bench therefore drives inputs on falling clock edges and reads per_dout and hold_busy on the falling edge after the third rising edge that follows the strobe release. hold_busy is checked at both ends of its window: it is still high HOLD_CYC-1 edges after the first check and low one edge later. Read direction is purely combinational after the two synchroniser stages, so the read checks sample two rising edges after rd_n and sel_n change. The violation flag lags the synchronised start of a write by one register, and it is read only after the offending write has completed.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef struct packed {
        logic wr_start;
        logic wr_commit;
        logic wr_active;
        logic rd_active;
    } hb_evt_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= {(STAGES*W){RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.stg[STAGES-1];
endmodule

// File: rtl/hb_strobe_ctrl.sv
module hb_strobe_ctrl
    import hb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_s,
    input  logic    wr_s,
    input  logic    rd_s,
    output hb_evt_t evt
);
    typedef struct packed {
        logic wr_prev;
        logic wr_owned;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d          = c_q;
        c_d.wr_prev  = wr_s;
        if (wr_s) begin
            c_d.wr_owned = 1'b0;
        end else if (!sel_s) begin
            c_d.wr_owned = 1'b1;
        end

        evt.wr_active = !wr_s && !sel_s;
        evt.wr_start  = c_q.wr_prev && !wr_s && !sel_s;
        evt.wr_commit = !c_q.wr_prev && wr_s && c_q.wr_owned;
        evt.rd_active = !rd_s && !sel_s && wr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{wr_prev: 1'b1, wr_owned: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/hb_hold_timer.sv
module hb_hold_timer #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_commit,
    output logic busy,
    output logic viol
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             viol;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr_commit) begin
            t_d.cnt = LOAD;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
        if (wr_start && (t_q.cnt != '0)) begin
            t_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = (t_q.cnt != '0);
    assign viol = t_q.viol;
endmodule

// File: rtl/hb_latch_path.sv
module hb_latch_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_s,
    input  logic         wr_active,
    input  logic         wr_commit,
    output logic [W-1:0] latched,
    output logic         drive
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] hold;
        logic         drive;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (wr_active) begin
            l_d.shadow = data_s;
        end
        if (wr_commit) begin
            l_d.hold  = l_q.shadow;
            l_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign latched = l_q.hold;
    assign drive   = l_q.drive;
endmodule

// File: rtl/hold_extend_buffer.sv
module hold_extend_buffer
    import hb_pkg::*;
#(
    parameter int W        = 8,
    parameter int HOLD_CYC = 8,
    parameter int SYNC_STG = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic [W-1:0] host_din,
    output logic [W-1:0] host_dout,
    output logic         host_oe,
    input  logic [W-1:0] per_din,
    output logic [W-1:0] per_dout,
    output logic         per_oe,
    output logic         hold_busy,
    output logic         hold_viol
);
    logic [2:0]   ctl_s;
    logic [W-1:0] data_s;
    logic         drive;
    hb_evt_t      evt;

    hb_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n, wr_n, rd_n}),
        .dout (ctl_s)
    );

    hb_sync #(.W(W), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_dat_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (host_din),
        .dout (data_s)
    );

    hb_strobe_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .sel_s(ctl_s[2]),
        .wr_s (ctl_s[1]),
        .rd_s (ctl_s[0]),
        .evt  (evt)
    );

    hb_latch_path #(.W(W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_s   (data_s),
        .wr_active(evt.wr_active),
        .wr_commit(evt.wr_commit),
        .latched  (per_dout),
        .drive    (drive)
    );

    hb_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (evt.wr_start),
        .wr_commit(evt.wr_commit),
        .busy     (hold_busy),
        .viol     (hold_viol)
    );

    always_comb begin
        host_oe   = evt.rd_active;
        host_dout = evt.rd_active ? per_din : '0;
        per_oe    = drive && !evt.rd_active;
    end
endmodule

// File: rtl/hold_extend_buffer_chk.sv
module hold_extend_buffer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] host_dout,
    input logic         host_oe,
    input logic [W-1:0] per_dout,
    input logic         per_oe,
    input logic         hold_busy,
    input logic         hold_viol
);
    AST_IDLE_ZERO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_oe && !host_oe) |-> (per_dout == '0)); // R1

    AST_DOUT_ONLY_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_dout) |-> (per_oe || host_oe)); // R2

    AST_READ_RELEASES_PER: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe |-> !per_oe); // R5

    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_oe |-> (host_dout == '0)); // R6

    AST_BUSY_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy |-> (per_oe || host_oe)); // R7

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |=> hold_viol); // R8
endmodule

bind hold_extend_buffer hold_extend_buffer_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_dout(host_dout),
    .host_oe  (host_oe),
    .per_dout (per_dout),
    .per_oe   (per_oe),
    .hold_busy(hold_busy),
    .hold_viol(hold_viol)
);

// File: tb/tb_hold_extend_buffer.sv
`timescale 1ns/1ps
module tb_hold_extend_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int HOLD_CYC   = 8;
    localparam int NVEC       = 6;

    // {sel_n, write data, expected per_dout afterwards}
    localparam logic [16:0] VECS [0:NVEC-1] = '{
        {1'b0, 8'hA5, 8'hA5},
        {1'b0, 8'h3C, 8'h3C},
        {1'b1, 8'hFF, 8'h3C},
        {1'b0, 8'h00, 8'h00},
        {1'b1, 8'h12, 8'h00},
        {1'b0, 8'h81, 8'h81}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [W-1:0] host_din = '0;
    logic [W-1:0] per_din = '0;
    logic [W-1:0] host_dout, per_dout;
    logic         host_oe, per_oe, hold_busy, hold_viol;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hold_extend_buffer #(.W(W), .HOLD_CYC(HOLD_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
        .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe),
        .per_din(per_din), .per_dout(per_dout), .per_oe(per_oe),
        .hold_busy(hold_busy), .hold_viol(hold_viol)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe low for 4 cycles, data scrambled as the strobe rises,
    // return on the falling edge after the third rising edge.
    task automatic do_write(input logic s_n, input logic [W-1:0] d);
        @(negedge clk);
        sel_n = s_n; host_din = d; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; host_din = ~d;
        @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 per_oe", {7'd0, per_oe}, 8'd0);
        chk("R1 per_dout", per_dout, 8'd0);
        rst_n = 1'b1;
        settle(3);
        chk("R1 host_oe", {7'd0, host_oe}, 8'd0);
        chk("R1 hold_busy", {7'd0, hold_busy}, 8'd0);
        chk("R1 hold_viol", {7'd0, hold_viol}, 8'd0);

        // R4: unselected write before any real one keeps zero and no drive
        do_write(1'b1, 8'h77);
        chk("R4 per_dout", per_dout, 8'd0);
        chk("R1 per_oe still off", {7'd0, per_oe}, 8'd0);
        settle(HOLD_CYC + 2);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i][16], VECS[i][15:8]);
            chk(VECS[i][16] ? "R4 vec" : "R2 vec", per_dout, VECS[i][7:0]);
            chk("R3 per_oe", {7'd0, per_oe}, 8'd1);
            settle(HOLD_CYC + 2);
        end
        chk("R9 hold_viol", {7'd0, hold_viol}, 8'd0);
        chk("R3 per_oe after idle", {7'd0, per_oe}, 8'd1);

        // R7: busy window length
        do_write(1'b0, 8'h5A);
        chk("R7 busy start", {7'd0, hold_busy}, 8'd1);
        chk("R2 5A", per_dout, 8'h5A);
        repeat (HOLD_CYC - 1) @(posedge clk);
        @(negedge clk);
        chk("R7 busy last", {7'd0, hold_busy}, 8'd1);
        @(posedge clk); @(negedge clk);
        chk("R7 busy end", {7'd0, hold_busy}, 8'd0);
        chk("R9 hold_viol again", {7'd0, hold_viol}, 8'd0);

        // R5: selected read
        @(negedge clk);
        per_din = 8'hC3; sel_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R5 host_oe", {7'd0, host_oe}, 8'd1);
        chk("R5 host_dout", host_dout, 8'hC3);
        chk("R5 per_oe", {7'd0, per_oe}, 8'd0);
        per_din = 8'h96;
        @(negedge clk);
        chk("R5 host_dout follows", host_dout, 8'h96);
        rd_n = 1'b1; sel_n = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R5 per_oe back", {7'd0, per_oe}, 8'd1);
        chk("R5 host_oe off", {7'd0, host_oe}, 8'd0);
        chk("R5 latch kept", per_dout, 8'h5A);

        // R6: unselected read
        rd_n = 1'b0; per_din = 8'hEE;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R6 host_oe", {7'd0, host_oe}, 8'd0);
        chk("R6 host_dout", host_dout, 8'd0);
        chk("R6 per_oe", {7'd0, per_oe}, 8'd1);
        rd_n = 1'b1;
        settle(3);

        // R8: back-to-back writes
        do_write(1'b0, 8'h11);
        chk("R8 first", per_dout, 8'h11);
        do_write(1'b0, 8'h22);
        chk("R8 hold_viol", {7'd0, hold_viol}, 8'd1);
        chk("R8 second data", per_dout, 8'h22);
        settle(HOLD_CYC + 2);
        do_write(1'b0, 8'h33);
        chk("R8 sticky", {7'd0, hold_viol}, 8'd1);
        chk("R2 33", per_dout, 8'h33);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule